// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block watches the instruction fetch stream of a processor and raises a breakpoint request when a fetch lands on an address that debug software has armed. Software programs it through a small word-addressed register port. It has one control word, which holds the global arm bit, and a set of comparator words. Each comparator word holds a word address, a compare enable and a two-bit halfword selector. The selector says which 16-bit halves of the watched word trigger: the lower half, the upper half, both, or none.

The fetch side presents a byte address with a valid strobe. Bit 1 of the address picks the halfword within the word. A matching fetch on any armed comparator sets the single registered hit output on the next clock edge. The core's halt logic consumes that output. A debug reset clears every arm bit. The comparator addresses and selectors keep whatever value they held, so software must program them before it arms them.

Top module: `ibp_unit`

## Requirements
- R1: After reset, `bkpt_hit` is 0, the control word at byte offset 0x00 reads 0x0000_0040, and bit 0 of every comparator word reads 0.
- R2: A write to offset 0x00 changes the global arm bit (bit 0) only when bit 1 of the written data is 1. Bit 1 always reads 0. Bits [7:4] always read the comparator count, which is 4, and ignore writes.
- R3: Comparator n sits at byte offset 0x08 + 4*n. It stores a selector in bits [31:30], a word address in bits [28:2] and an enable in bit 0. Bits 29 and 1 read 0.
- R4: Selector encoding: 00 never triggers, 01 triggers on the lower halfword (fetch address bit 1 = 0), 10 triggers on the upper halfword (bit 1 = 1), and 11 triggers on either.
- R5: A comparator triggers only when its own enable and the global arm bit are both 1.
- R6: A fetch triggers only while `fetch_valid` is 1, only if fetch address bits [28:2] equal the stored word address, and only if fetch address bits [31:29] are zero.
- R7: `bkpt_hit` is registered. It is 1 exactly in the cycle after a fetch that triggers at least one comparator, so it is the OR of all comparators, delayed by one clock.
- R8: Reads from offsets with no register return 0. Writes to those offsets change no register.
- R9: A fetch of the upper halfword of a watched word triggers under selector 10 or 11. This covers the second half of a 32-bit instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high debug reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| bkpt_hit | output | 1 | Registered breakpoint request |

## Verification
The hardest case to reach from the ports is two or more comparators that watch the same word with different halfword selectors while the global arm bit toggles. Uniform random addresses almost never produce that case. The random stimulus therefore draws comparator word addresses from a pool of sixteen values, and draws most fetch addresses from that same pool with a random halfword bit. Some fetch addresses also get random upper bits set. Directed cases walk a single comparator through all four selectors on both halves of a word. They also cover keyless control writes, writes to unmapped offsets, and the one-cycle latency of the hit output.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

    localparam int DATA_W        = 32;
    localparam int WADDR_LO      = 2;
    localparam int WADDR_HI      = 28;
    localparam int WADDR_W       = WADDR_HI - WADDR_LO + 1;
    localparam int CTRL_WORD     = 0;
    localparam int CMP_BASE_WORD = 2;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_LOWER = 2'b01,
        SEL_UPPER = 2'b10,
        SEL_BOTH  = 2'b11
    } half_sel_e;

    typedef struct packed {
        half_sel_e          sel;
        logic [WADDR_W-1:0] waddr;
        logic               en;
    } cmp_cfg_t;

    function automatic logic [DATA_W-1:0] pack_cmp(input cmp_cfg_t c);
        return {c.sel, 1'b0, c.waddr, 1'b0, c.en};
    endfunction

    function automatic logic half_selected(input half_sel_e s, input logic upper);
        return upper ? s[1] : s[0];
    endfunction

endpackage

// File: rtl/ibp_regs.sv
module ibp_regs
    import ibp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic                       glb_en_o,
    output cmp_cfg_t [NUM_CMP-1:0]     cfg_o
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [3:0] NUM_CODE = 4'(NUM_CMP);

    logic [WORD_W-1:0] word;
    logic              glb_en_q;
    logic              en_q  [NUM_CMP];
    half_sel_e         sel_q [NUM_CMP];
    logic [WADDR_W-1:0] wa_q [NUM_CMP];
    logic              mapped;

    assign word     = addr_i[ADDR_W-1:2];
    assign glb_en_o = glb_en_q;

    // Global arm bit: updated only when the key bit is set in the write data.
    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en_q <= 1'b0;
        end else if (we_i && word == WORD_W'(CTRL_WORD) && wdata_i[1]) begin
            glb_en_q <= wdata_i[0];
        end
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_reg
        localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(CMP_BASE_WORD + g);

        // Enable is cleared by reset.
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[g] <= 1'b0;
            end else if (we_i && word == MY_WORD) begin
                en_q[g] <= wdata_i[0];
            end
        end

        // Address and selector carry no reset.
        always_ff @(posedge clk) begin
            if (we_i && word == MY_WORD) begin
                sel_q[g] <= half_sel_e'(wdata_i[31:30]);
                wa_q[g]  <= wdata_i[WADDR_HI:WADDR_LO];
            end
        end

        assign cfg_o[g] = '{sel: sel_q[g], waddr: wa_q[g], en: en_q[g]};
    end

    always_comb begin
        rdata_o = '0;
        mapped  = 1'b0;
        if (word == WORD_W'(CTRL_WORD)) begin
            rdata_o = {24'b0, NUM_CODE, 3'b000, glb_en_q};
            mapped  = 1'b1;
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (word == WORD_W'(CMP_BASE_WORD + i)) begin
                rdata_o = pack_cmp(cfg_o[i]);
                mapped  = 1'b1;
            end
        end
    end

    a_r2_keyless_write: assert property (@(posedge clk) disable iff (rst)
        (we_i && word == WORD_W'(CTRL_WORD) && !wdata_i[1]) |=> $stable(glb_en_q));

    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (we_i && !mapped) |=> ($stable(glb_en_q) && $stable(cfg_o)));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!glb_en_q && !en_q[0]));

endmodule

// File: rtl/ibp_cmp.sv
module ibp_cmp
    import ibp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid_i,
    input  logic [DATA_W-1:0] fetch_addr_i,
    input  logic              glb_en_i,
    input  cmp_cfg_t          cfg_i,
    output logic              match_o
);

    logic addr_eq;
    logic top_clear;
    logic half_ok;

    assign top_clear = (fetch_addr_i[DATA_W-1:WADDR_HI+1] == '0);
    assign addr_eq   = (fetch_addr_i[WADDR_HI:WADDR_LO] == cfg_i.waddr);
    assign half_ok   = half_selected(cfg_i.sel, fetch_addr_i[1]);
    assign match_o   = fetch_valid_i && glb_en_i && cfg_i.en
                       && top_clear && addr_eq && half_ok;

    a_r6_high_bits_block: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr_i[DATA_W-1:WADDR_HI+1] != '0) |-> !match_o);

    a_r4_none_never: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.sel == SEL_NONE) |-> !match_o);

endmodule

// File: rtl/ibp_unit.sv
module ibp_unit
    import ibp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              bkpt_hit
);

    logic                   glb_en;
    cmp_cfg_t [NUM_CMP-1:0] cfg;
    logic [NUM_CMP-1:0]     hits;
    logic                   any_match;
    logic                   hit_q;

    ibp_regs #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .glb_en_o (glb_en),
        .cfg_o    (cfg)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        ibp_cmp cmp_i (
            .clk           (clk),
            .rst           (rst),
            .fetch_valid_i (fetch_valid),
            .fetch_addr_i  (fetch_addr),
            .glb_en_i      (glb_en),
            .cfg_i         (cfg[g]),
            .match_o       (hits[g])
        );
    end

    assign any_match = |hits;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= any_match;
        end
    end

    assign bkpt_hit = hit_q;

    a_r7_hit_follows: assert property (@(posedge clk) disable iff (rst)
        any_match |=> bkpt_hit);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !any_match |=> !bkpt_hit);

    a_r5_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (!glb_en || !fetch_valid) |=> !bkpt_hit);

endmodule

// File: tb/ibp_unit_tb_top.sv
`timescale 1ns/1ps
module ibp_unit_tb_top;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        bkpt_hit;

    int total = 0;
    int bad   = 0;

    // bench model
    logic        m_glb;
    logic        m_en   [N];
    logic [1:0]  m_sel  [N];
    logic [26:0] m_wa   [N];

    always #5 clk = ~clk;

    ibp_unit #(.NUM_CMP(N), .ADDR_W(12)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .bkpt_hit    (bkpt_hit)
    );

    function automatic logic exp_hit(input logic v, input logic [31:0] a);
        logic r = 1'b0;
        if (!v || !m_glb || a[31:29] != 3'b0) return 1'b0;
        for (int i = 0; i < N; i++) begin
            if (m_en[i] && a[28:2] == m_wa[i] && (a[1] ? m_sel[i][1] : m_sel[i][0]))
                r = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int w = int'(a[11:2]);
        if (w == 0) return {24'b0, 4'(N), 3'b0, m_glb};
        if (w >= 2 && w < 2 + N)
            return {m_sel[w-2], 1'b0, m_wa[w-2], 1'b0, m_en[w-2]};
        return 32'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        int w = int'(a[11:2]);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (w == 0) begin
            if (d[1]) m_glb = d[0];
        end else if (w >= 2 && w < 2 + N) begin
            m_sel[w-2] = d[31:30];
            m_wa[w-2]  = d[28:2];
            m_en[w-2]  = d[0];
        end
    endtask

    task automatic rd_check(input string req, input logic [11:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp_read(a));
    endtask

    // Drive a fetch for one cycle; bkpt_hit is checked one clock later.
    task automatic fetch(input string req, input logic v, input logic [31:0] a);
        logic e;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        e = exp_hit(v, a);
        @(negedge clk);
        check(req, {31'b0, bkpt_hit}, {31'b0, e});
        fetch_valid = 1'b0;
    endtask

    function automatic logic [31:0] cmp_word(input logic [1:0] s, input logic [26:0] wa, input logic en);
        return {s, 1'b0, wa, 1'b0, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_glb = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_en[i] = 1'b0; m_sel[i] = 2'b00; m_wa[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 hit", {31'b0, bkpt_hit}, 32'b0);
        @(negedge clk); reg_addr = 12'h000; #1;
        check("R1 ctrl", reg_rdata, 32'h0000_0040);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); reg_addr = 12'(8 + 4 * i); #1;
            check("R1 cmp en", {31'b0, reg_rdata[0]}, 32'b0);
        end

        // program all comparators before use
        for (int i = 0; i < N; i++) wr(12'(8 + 4 * i), cmp_word(2'b00, 27'(i), 1'b0));

        // R2: key protection
        wr(12'h000, 32'h0000_0001);
        rd_check("R2 keyless", 12'h000);
        wr(12'h000, 32'hFFFF_FFF3);
        rd_check("R2 keyed", 12'h000);
        check("R2 readback", reg_rdata, 32'h0000_0041);

        // R3: field layout
        wr(12'h008, 32'hFFFF_FFFF);
        rd_check("R3 layout", 12'h008);
        check("R3 reserved zero", reg_rdata, 32'hDFFF_FFFD);
        wr(12'h008, cmp_word(2'b00, 27'h40, 1'b1));

        // R8: unmapped offsets
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h018, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        rd_check("R8 off04", 12'h004);
        rd_check("R8 off18", 12'h018);
        rd_check("R8 offFFC", 12'hFFC);
        rd_check("R8 ctrl kept", 12'h000);
        rd_check("R8 cmp0 kept", 12'h008);

        // R4 / R9: selector walk on word 0x40 (byte 0x100)
        for (int s = 0; s < 4; s++) begin
            wr(12'h008, cmp_word(2'(s), 27'h40, 1'b1));
            fetch("R4 lower", 1'b1, 32'h0000_0100);
            fetch("R9 upper", 1'b1, 32'h0000_0102);
        end

        // R5: both enables needed
        wr(12'h000, 32'h0000_0002);
        fetch("R5 global off", 1'b1, 32'h0000_0100);
        wr(12'h000, 32'h0000_0003);
        wr(12'h008, cmp_word(2'b11, 27'h40, 1'b0));
        fetch("R5 cmp off", 1'b1, 32'h0000_0100);
        wr(12'h008, cmp_word(2'b11, 27'h40, 1'b1));

        // R6: valid and upper address bits
        fetch("R6 invalid", 1'b0, 32'h0000_0100);
        fetch("R6 high bits", 1'b1, 32'h2000_0100);
        fetch("R6 other word", 1'b1, 32'h0000_0104);

        // R7: exact one-cycle latency
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h0000_0100;
        #1 check("R7 not early", {31'b0, bkpt_hit}, 32'b0);
        @(negedge clk);
        fetch_valid = 1'b0;
        check("R7 one cycle", {31'b0, bkpt_hit}, 32'b1);
        @(negedge clk);
        check("R7 drops", {31'b0, bkpt_hit}, 32'b0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int r = int'($urandom % 100);
            if (r < 20) begin
                int k = int'($urandom % N);
                wr(12'(8 + 4 * k), cmp_word(2'($urandom), 27'($urandom % 16), 1'($urandom))
                                   | ({31'b0, 1'b0} | (32'($urandom) & 32'h2000_0002)));
                rd_check("R3 random", 12'(8 + 4 * k));
            end else if (r < 25) begin
                wr(12'h000, 32'($urandom));
                rd_check("R2 random", 12'h000);
            end else begin
                logic [31:0] a = {3'b0, 25'b0, 4'($urandom)} << 2;
                a[1] = 1'($urandom);
                if ($urandom % 8 == 0) a[31:29] = 3'($urandom);
                fetch("R7 random", ($urandom % 8) != 0, a);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule